// File: doc/BRIEF.md
# Serial Port Status Flags with Two-Step Clearing

The block holds the eight status flags of an asynchronous serial port in one byte and lets software clear them safely. The transmitter and receiver cores report events as single-cycle set pulses. Software sees a register bus with a status register and a data register. A flag clears only after two accesses: first a status read, then an access to the data register. A data read clears receive flags and a data write clears transmit flags.

A status read takes a snapshot of the flags and arms the sequence. The data access that follows uses up the armed state and clears only those flags that were set in the snapshot. An event that arrives between the two accesses is therefore never lost. A data write that is not armed is dropped and no byte goes to the transmitter.

Top module: `uart_flag_ctrl`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0: transmit holding empty, transmit idle, receive full, line idle, overrun, noise, framing error, parity error. After reset it reads 8'hC0.
- R2: A 1 on bit i of `evt_set_i` sets status bit i on the next clock edge. A set flag stays 1 until the clear sequence removes it.
- R3: A status read (`rd_i`=1, `sel_data_i`=0) followed by a data read (`rd_i`=1, `sel_data_i`=1) clears each of bits 5..0 that was 1 at the status read. Bits 7..6 are left as they are.
- R4: A receive flag that becomes 1 after the status read is still 1 after the data read that completes the sequence.
- R5: A status read followed by a data write (`wr_i`=1, `sel_data_i`=1) clears each of bits 7..6 that was 1 at the status read. Bits 5..0 are left as they are.
- R6: A data write that has no pending status read produces no `tx_load_o` pulse and leaves every flag unchanged.
- R7: An accepted data write drives `tx_load_o` high for exactly the one cycle after the write edge, with `tx_data_o` equal to the written byte.
- R8: Writing the status register has no effect. Reading the status register never changes a flag.
- R9: If a set pulse and a clear for the same flag arrive in the same cycle, the flag ends at 1.
- R10: Every data access uses up the pending status read. A second data access without a new status read clears nothing and does not load the transmitter.
- R11: `rdata_o` shows `rx_data_i` combinationally when `sel_data_i`=1, and the status byte when `sel_data_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Single-cycle read strobe |
| wr_i | input | 1 | Single-cycle write strobe |
| sel_data_i | input | 1 | 0 selects status, 1 selects data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rx_data_i | input | 8 | Received byte from the receiver core |
| evt_set_i | input | 8 | Flag set pulses, bit positions as in the status byte |
| tx_load_o | output | 1 | Pulse that hands a byte to the transmitter |
| tx_data_o | output | 8 | Byte handed to the transmitter |

## Verification
The hardest case to reach is a flag that sets between the status read and the data access, because the snapshot and the live flags then disagree. The bench sweeps all 64 receive patterns for the snapshot. For each one it pulses a second, different pattern between the two accesses, then predicts the remaining flags as the second pattern with the snapshot bits removed. A set pulse in the same cycle as the clearing data read covers the collision case.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int FLAG_W = 8;
  localparam int RX_W   = 6;
  localparam logic [FLAG_W-1:0] FLAG_RST = 8'hC0;
  localparam logic [FLAG_W-1:0] RX_MASK  = 8'h3F;
  localparam logic [FLAG_W-1:0] TX_MASK  = 8'hC0;
  typedef enum int {
    F_PAR = 0, F_FRM = 1, F_NSE = 2, F_OVR = 3,
    F_LIDLE = 4, F_RXFULL = 5, F_TXIDLE = 6, F_TXEMPTY = 7
  } flag_bit_e;
endpackage

// File: rtl/ufc_flag_bank.sv
module ufc_flag_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= (q & ~clr_i) | set_i;
  end
  assign flags_o = q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i) & ~flags_o) == '0)); // R9
  AST_HOLD_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(flags_o) & ~$past(clr_i)) & ~flags_o) == '0)); // R2
endmodule

// File: rtl/ufc_arm_snap.sv
module ufc_arm_snap #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stat_rd_i,
  input  logic         data_acc_i,
  input  logic [W-1:0] flags_i,
  output logic         armed_o,
  output logic [W-1:0] snap_o
);
  logic         armed_q;
  logic [W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      snap_q  <= '0;
    end else if (stat_rd_i) begin
      armed_q <= 1'b1;
      snap_q  <= flags_i;
    end else if (data_acc_i) begin
      armed_q <= 1'b0;
    end
  end
  assign armed_o = armed_q;
  assign snap_o  = snap_q;

  AST_ARM_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && !stat_rd_i) |=> !armed_o); // R10
  AST_SNAP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> (armed_o && snap_o == $past(flags_i))); // R3
endmodule

// File: rtl/ufc_tx_gate.sv
module ufc_tx_gate #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ok_i,
  input  logic [DW-1:0] wdata_i,
  output logic          load_o,
  output logic [DW-1:0] data_o
);
  logic          load_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      data_q <= '0;
    end else begin
      load_q <= wr_ok_i;
      if (wr_ok_i) data_q <= wdata_i;
    end
  end
  assign load_o = load_q;
  assign data_o = data_q;

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !wr_ok_i) |=> !load_o); // R7
  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_i |=> (load_o && data_o == $past(wdata_i))); // R7
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              sel_data_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     rx_data_i,
  input  logic [FLAG_W-1:0] evt_set_i,
  output logic              tx_load_o,
  output logic [DW-1:0]     tx_data_o
);
  logic              stat_rd, data_rd, data_wr, data_acc;
  logic              armed, rx_ok, tx_ok;
  logic [FLAG_W-1:0] flags, snap, clr;

  assign stat_rd  = rd_i & ~sel_data_i;
  assign data_rd  = rd_i & sel_data_i;
  assign data_wr  = wr_i & sel_data_i;
  assign data_acc = data_rd | data_wr;
  assign rx_ok    = data_rd & armed;
  assign tx_ok    = data_wr & armed;

  // clear only snapshot bits of the group matching the access
  for (genvar i = 0; i < FLAG_W; i++) begin : g_clr
    if (i >= RX_W) begin : g_tx
      assign clr[i] = snap[i] & tx_ok;
    end else begin : g_rx
      assign clr[i] = snap[i] & rx_ok;
    end
  end

  ufc_flag_bank #(.W(FLAG_W), .RST_VAL(FLAG_RST)) u_bank (
    .clk_i, .rst_ni, .set_i(evt_set_i), .clr_i(clr), .flags_o(flags)
  );

  ufc_arm_snap #(.W(FLAG_W)) u_arm (
    .clk_i, .rst_ni, .stat_rd_i(stat_rd), .data_acc_i(data_acc),
    .flags_i(flags), .armed_o(armed), .snap_o(snap)
  );

  ufc_tx_gate #(.DW(DW)) u_tx (
    .clk_i, .rst_ni, .wr_ok_i(tx_ok), .wdata_i(wdata_i),
    .load_o(tx_load_o), .data_o(tx_data_o)
  );

  assign rdata_o = sel_data_i ? rx_data_i : DW'(flags);

  AST_TX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> $past(wr_i && sel_data_i && armed)); // R6
  AST_CLR_ONLY_SNAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(flags) & ~flags) & ~$past(snap)) == '0)); // R4
  AST_STATUS_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_acc) |=> (flags == ($past(flags) | $past(evt_set_i)))); // R8
  AST_RX_GROUP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !wr_i) |=> ((flags & TX_MASK) == (($past(flags) | $past(evt_set_i)) & TX_MASK))); // R3
endmodule

// File: tb/uart_flag_ctrl_tb.sv
module uart_flag_ctrl_tb;
  logic       clk = 0, rst_n = 0;
  logic       rd = 0, wr = 0, sel = 0;
  logic [7:0] wdata = 0, rdata, rx_data = 0, evt = 0, tx_data;
  logic       tx_load;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  uart_flag_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .sel_data_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data),
    .evt_set_i(evt), .tx_load_o(tx_load), .tx_data_o(tx_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic stat_rd(output logic [7:0] val);
    rd = 1; sel = 0; #1 val = rdata; tick(); rd = 0;
  endtask

  task automatic data_rd(input logic [7:0] ev);
    rd = 1; sel = 1; evt = ev; tick(); rd = 0; evt = 0;
  endtask

  task automatic data_wr(input logic [7:0] b);
    wr = 1; sel = 1; wdata = b; tick(); wr = 0;
  endtask

  task automatic pulse(input logic [7:0] m);
    evt = m; tick(); evt = 0;
  endtask

  task automatic peek(output logic [7:0] val);
    sel = 0; #1 val = rdata;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset
    peek(v); chk("R1", v, 8'hC0);
    chk("R7", {7'd0, tx_load}, 8'd0);

    // R11 data read path
    rx_data = 8'h5A; sel = 1; #1 chk("R11", rdata, 8'h5A); sel = 0;

    // R8 status write has no effect, status read does not alter
    wr = 1; sel = 0; wdata = 8'h00; tick(); wr = 0;
    peek(v); chk("R8", v, 8'hC0);
    stat_rd(v); stat_rd(v); chk("R8", v, 8'hC0);

    // R2 R3 R4 sweep over all receive snapshots
    for (int p = 0; p < 64; p++) begin
      logic [7:0] q;
      q = 8'((p * 37 + 11) & 63);
      pulse(8'(p));
      stat_rd(v); chk("R2", v, 8'hC0 | 8'(p));
      pulse(q);
      data_rd(8'h00);
      peek(v); chk("R4", v, 8'hC0 | (q & ~8'(p)));
      stat_rd(v); data_rd(8'h00);
      peek(v); chk("R3", v, 8'hC0);
    end

    // R5 R7 sweep over transmit flag patterns
    for (int t = 0; t < 4; t++) begin
      stat_rd(v); data_wr(8'hA0 + 8'(t));
      chk("R7", {7'd0, tx_load}, 8'd1);
      chk("R7", tx_data, 8'hA0 + 8'(t));
      tick(); chk("R7", {7'd0, tx_load}, 8'd0);
      peek(v); chk("R5", v, 8'h00);
      pulse(8'(t << 6) | 8'h01);
      stat_rd(v); chk("R5", v, 8'(t << 6) | 8'h01);
      data_wr(8'h30 + 8'(t));
      chk("R7", {7'd0, tx_load}, 8'd1);
      peek(v); chk("R5", v, 8'h01);
      stat_rd(v); data_rd(8'h00);
      peek(v); chk("R3", v, 8'h00);
    end

    // R6 unarmed write ignored
    pulse(8'hC0);
    data_wr(8'h77);
    chk("R6", {7'd0, tx_load}, 8'd0);
    chk("R6", tx_data, 8'h33);
    peek(v); chk("R6", v, 8'hC0);

    // R10 armed state used up by a data read
    pulse(8'h04);
    stat_rd(v); data_rd(8'h00);
    peek(v); chk("R10", v, 8'hC0);
    data_wr(8'h66);
    chk("R10", {7'd0, tx_load}, 8'd0);
    peek(v); chk("R10", v, 8'hC0);
    pulse(8'h08);
    data_rd(8'h00);
    peek(v); chk("R10", v, 8'hC8);

    // R9 set and clear collide
    stat_rd(v); chk("R9", v, 8'hC8);
    data_rd(8'h08);
    peek(v); chk("R9", v, 8'hC8);
    stat_rd(v); data_rd(8'h00);
    peek(v); chk("R3", v, 8'hC0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule